// File: doc/BRIEF.md
# LIN Request and Error-Policy Control Register

This block is one 32-bit memory-mapped control word inside a LIN protocol controller. It holds two error-policy bits and three request bits. The policy bits decide whether a detected bit error or an identifier parity error sends the LIN state machine back to idle. The request bits ask the frame engine to send a wake-up character, to drop the data of a frame that does not concern this node, or to transmit the data field. The frame engine, the filters and the baud logic sit outside this block.

Software writes the word through a simple select/write-enable bus port. Request bits are write-one-to-set, and writing 0 to them does nothing. Each request bit has its own gating on mode and status. The engine's event inputs clear the request bits, and in master mode one event sets the transmit request. Each request bit is a two-state machine: REQ_OFF and REQ_ON. The transition REQ_OFF to REQ_ON takes a qualified set with no clear present. The transition REQ_ON to REQ_OFF takes any clear event. When a clear event and a set arrive in the same cycle, the bit goes to REQ_OFF.

The block also drives two outputs to the engine. `goto_idle_o` applies the policy bits to the engine's error events. `bit_chk_en_o` is low while a wake-up character is being sent, so bit errors are not checked then.

Top module: `lin_req_ctl_reg`

## Requirements
- R1: A read with `bus_addr` = 0x30 returns the bit-error policy in bit 16, the parity policy in bit 17, the wake-up request in bit 18, the discard request in bit 19 and the transmit request in bit 20. Every other bit reads 0. A read at any other address, or with no read strobe, returns 0.
- R2: When `rst_n` is low, the bit-error policy loads the value of `cfg_slave`, so it is 1 in slave mode and 0 in master mode. The parity policy and all three request bits reset to 0.
- R3: A write to 0x30 loads the two policy bits from `bus_wdata[17:16]` only while `mode_init` is 1. Any other write leaves them unchanged.
- R4: `goto_idle_o` is 1 when `par_err` is 1 and the parity policy is 1. It is also 1 when `bit_err` is 1, the bit-error policy is 1 and bit checking is enabled. Otherwise it is 0.
- R5: Writing 1 to bit 18 sets the wake-up request unless `mode_sleep` is 1. In sleep mode the write is ignored. Writing 0 to any request bit has no effect.
- R6: `wkup_sent` clears the wake-up request. `bit_chk_en_o` is 0 exactly while the wake-up request is set.
- R7: Writing 1 to bit 19 sets the discard request. In slave mode the write needs `hdr_rcvd` = 1 and `filt_match` = 0. In master mode the write is not gated.
- R8: `eng_idle` clears the discard request.
- R9: Writing 1 to bit 20 sets the transmit request in slave mode only while `hdr_rcvd` = 1. In master mode a software set of this bit is ignored.
- R10: Any of `xfer_done`, `xfer_abort` or `xfer_err` clears the transmit request.
- R11: In master mode, `hdr_tx_done` together with `dir_tx` = 1 sets the transmit request.
- R12: When a clear event arrives in the same cycle as a software or hardware set of the same request bit, the clear wins and the bit reads 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_slave | input | 1 | 1 = node is slave, 0 = master |
| mode_init | input | 1 | Initialization mode flag |
| mode_sleep | input | 1 | Sleep mode flag |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| hdr_rcvd | input | 1 | Header-received status flag |
| filt_match | input | 1 | Identifier matched a filter |
| wkup_sent | input | 1 | Wake-up character transmitted |
| eng_idle | input | 1 | Engine reached idle state |
| xfer_done | input | 1 | Data transfer completed |
| xfer_abort | input | 1 | Data transfer aborted |
| xfer_err | input | 1 | Error during transfer |
| hdr_tx_done | input | 1 | Header transmission finished (master) |
| dir_tx | input | 1 | Direction selects transmit |
| bit_err | input | 1 | Bit error detected |
| par_err | input | 1 | Identifier parity error detected |
| pol_bit_idle_o | output | 1 | Bit-error idle policy |
| pol_par_idle_o | output | 1 | Parity-error idle policy |
| req_wkup_o | output | 1 | Wake-up request |
| req_discard_o | output | 1 | Discard request |
| req_tx_o | output | 1 | Transmit-data request |
| bit_chk_en_o | output | 1 | Bit-error checking enabled |
| goto_idle_o | output | 1 | Return LIN state machine to idle |

## Verification
Two things can land on the same request bit in one cycle: a set and a clear. The set can be a software write-one or the master-mode header event. The clear can be the wake-up-sent, idle or transfer-end event. Directed vectors raise a write-one to each request bit together with its clear event. A master-mode vector raises `hdr_tx_done` with `xfer_err`. In each case the bit must read 0 the next cycle. The random phase also drives events and writes at rates high enough that such collisions happen often. A bench model, in which clear has priority, judges every one of them.

// File: rtl/lin_req_pkg.sv
package lin_req_pkg;
    localparam int unsigned DATA_W   = 32;
    localparam int unsigned ADDR_W   = 8;
    localparam int unsigned NUM_REQ  = 3;

    // field positions inside the 32-bit word
    localparam int unsigned POS_POL_BIT = 16;
    localparam int unsigned POS_POL_PAR = 17;
    localparam int unsigned POS_REQ_LO  = 18;

    // request indices, offset from POS_REQ_LO
    localparam int unsigned IDX_WKUP = 0;
    localparam int unsigned IDX_DISC = 1;
    localparam int unsigned IDX_TX   = 2;

    typedef enum logic {
        REQ_OFF = 1'b0,
        REQ_ON  = 1'b1
    } req_state_t;
endpackage

// File: rtl/lin_req_cell.sv
module lin_req_cell
    import lin_req_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic req_o
);
    req_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            REQ_OFF: if (set_i && !clr_i) state_d = REQ_ON;
            REQ_ON:  if (clr_i)           state_d = REQ_OFF;
            default:                      state_d = REQ_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= REQ_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        req_o = (state_q == REQ_ON);
    end
endmodule

// File: rtl/lin_policy_bits.sv
module lin_policy_bits (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_slave,
    input  logic load_i,
    input  logic bit_d,
    input  logic par_d,
    output logic pol_bit_o,
    output logic pol_par_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_bit_o <= cfg_slave;
            pol_par_o <= 1'b0;
        end else if (load_i) begin
            pol_bit_o <= bit_d;
            pol_par_o <= par_d;
        end
    end
endmodule

// File: rtl/lin_req_decode.sv
module lin_req_decode
    import lin_req_pkg::*;
#(
    parameter logic [ADDR_W-1:0] REG_OFS = 8'h30
) (
    input  logic               cfg_slave,
    input  logic               mode_init,
    input  logic               mode_sleep,
    input  logic               bus_sel,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic               hdr_rcvd,
    input  logic               filt_match,
    input  logic               wkup_sent,
    input  logic               eng_idle,
    input  logic               xfer_done,
    input  logic               xfer_abort,
    input  logic               xfer_err,
    input  logic               hdr_tx_done,
    input  logic               dir_tx,
    output logic               pol_load_o,
    output logic               rd_hit_o,
    output logic [NUM_REQ-1:0] set_o,
    output logic [NUM_REQ-1:0] clr_o
);
    logic                wr_hit;
    logic [NUM_REQ-1:0]  w1s;

    always_comb begin
        wr_hit     = bus_sel && bus_we && (bus_addr == REG_OFS);
        rd_hit_o   = bus_sel && !bus_we && (bus_addr == REG_OFS);
        pol_load_o = wr_hit && mode_init;
        w1s        = wr_hit ? bus_wdata[POS_REQ_LO +: NUM_REQ] : '0;

        set_o[IDX_WKUP] = w1s[IDX_WKUP] && !mode_sleep;
        set_o[IDX_DISC] = w1s[IDX_DISC] && (!cfg_slave || (hdr_rcvd && !filt_match));
        set_o[IDX_TX]   = (w1s[IDX_TX] && cfg_slave && hdr_rcvd)
                       || (!cfg_slave && hdr_tx_done && dir_tx);

        clr_o[IDX_WKUP] = wkup_sent;
        clr_o[IDX_DISC] = eng_idle;
        clr_o[IDX_TX]   = xfer_done || xfer_abort || xfer_err;
    end
endmodule

// File: rtl/lin_req_ctl_reg.sv
module lin_req_ctl_reg
    import lin_req_pkg::*;
#(
    parameter logic [ADDR_W-1:0] REG_OFS = 8'h30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_slave,
    input  logic              mode_init,
    input  logic              mode_sleep,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              hdr_rcvd,
    input  logic              filt_match,
    input  logic              wkup_sent,
    input  logic              eng_idle,
    input  logic              xfer_done,
    input  logic              xfer_abort,
    input  logic              xfer_err,
    input  logic              hdr_tx_done,
    input  logic              dir_tx,
    input  logic              bit_err,
    input  logic              par_err,
    output logic              pol_bit_idle_o,
    output logic              pol_par_idle_o,
    output logic              req_wkup_o,
    output logic              req_discard_o,
    output logic              req_tx_o,
    output logic              bit_chk_en_o,
    output logic              goto_idle_o
);
    logic               pol_load;
    logic               rd_hit;
    logic [NUM_REQ-1:0] set_v, clr_v, req_v;

    lin_req_decode #(.REG_OFS(REG_OFS)) dec_i (
        .cfg_slave  (cfg_slave),
        .mode_init  (mode_init),
        .mode_sleep (mode_sleep),
        .bus_sel    (bus_sel),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .hdr_rcvd   (hdr_rcvd),
        .filt_match (filt_match),
        .wkup_sent  (wkup_sent),
        .eng_idle   (eng_idle),
        .xfer_done  (xfer_done),
        .xfer_abort (xfer_abort),
        .xfer_err   (xfer_err),
        .hdr_tx_done(hdr_tx_done),
        .dir_tx     (dir_tx),
        .pol_load_o (pol_load),
        .rd_hit_o   (rd_hit),
        .set_o      (set_v),
        .clr_o      (clr_v)
    );

    lin_policy_bits pol_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_slave(cfg_slave),
        .load_i   (pol_load),
        .bit_d    (bus_wdata[POS_POL_BIT]),
        .par_d    (bus_wdata[POS_POL_PAR]),
        .pol_bit_o(pol_bit_idle_o),
        .pol_par_o(pol_par_idle_o)
    );

    for (genvar g = 0; g < NUM_REQ; g++) begin : g_req
        lin_req_cell cell_i (
            .clk  (clk),
            .rst_n(rst_n),
            .set_i(set_v[g]),
            .clr_i(clr_v[g]),
            .req_o(req_v[g])
        );
    end

    always_comb begin
        req_wkup_o    = req_v[IDX_WKUP];
        req_discard_o = req_v[IDX_DISC];
        req_tx_o      = req_v[IDX_TX];
        bit_chk_en_o  = !req_v[IDX_WKUP];
        goto_idle_o   = (bit_err && bit_chk_en_o && pol_bit_idle_o)
                     || (par_err && pol_par_idle_o);
        bus_rdata     = '0;
        if (rd_hit) begin
            bus_rdata[POS_POL_BIT]               = pol_bit_idle_o;
            bus_rdata[POS_POL_PAR]               = pol_par_idle_o;
            bus_rdata[POS_REQ_LO +: NUM_REQ]     = req_v;
        end
    end
endmodule

// File: rtl/lin_req_ctl_reg_chk.sv
module lin_req_ctl_reg_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_slave,
    input logic        mode_init,
    input logic        mode_sleep,
    input logic [31:0] bus_rdata,
    input logic        filt_match,
    input logic        wkup_sent,
    input logic        eng_idle,
    input logic        xfer_done,
    input logic        xfer_abort,
    input logic        xfer_err,
    input logic        hdr_tx_done,
    input logic        dir_tx,
    input logic        bit_err,
    input logic        pol_bit_idle_o,
    input logic        pol_par_idle_o,
    input logic        req_wkup_o,
    input logic        req_discard_o,
    input logic        req_tx_o,
    input logic        goto_idle_o
);
    assert_low_half_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[15:0] == 16'h0);

    assert_policy_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_init |=> ($stable(pol_bit_idle_o) && $stable(pol_par_idle_o)));

    assert_sleep_blocks_wkup_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sleep && !req_wkup_o) |=> !req_wkup_o);

    assert_no_bit_idle_in_wkup_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_err && req_wkup_o && !pol_par_idle_o) |-> !goto_idle_o);

    assert_filter_blocks_discard_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_slave && filt_match && !req_discard_o) |=> !req_discard_o);

    assert_master_hw_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_slave && hdr_tx_done && dir_tx && !xfer_done && !xfer_abort && !xfer_err)
        |=> req_tx_o);

    assert_wkup_clear_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
        wkup_sent |=> !req_wkup_o);

    assert_disc_clear_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
        eng_idle |=> !req_discard_o);

    assert_tx_clear_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done || xfer_abort || xfer_err) |=> !req_tx_o);
endmodule

bind lin_req_ctl_reg lin_req_ctl_reg_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_slave     (cfg_slave),
    .mode_init     (mode_init),
    .mode_sleep    (mode_sleep),
    .bus_rdata     (bus_rdata),
    .filt_match    (filt_match),
    .wkup_sent     (wkup_sent),
    .eng_idle      (eng_idle),
    .xfer_done     (xfer_done),
    .xfer_abort    (xfer_abort),
    .xfer_err      (xfer_err),
    .hdr_tx_done   (hdr_tx_done),
    .dir_tx        (dir_tx),
    .bit_err       (bit_err),
    .pol_bit_idle_o(pol_bit_idle_o),
    .pol_par_idle_o(pol_par_idle_o),
    .req_wkup_o    (req_wkup_o),
    .req_discard_o (req_discard_o),
    .req_tx_o      (req_tx_o),
    .goto_idle_o   (goto_idle_o)
);

// File: tb/lin_req_ctl_reg_tb_top.sv
`timescale 1ns/1ps
module lin_req_ctl_reg_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_slave, mode_init, mode_sleep;
    logic        bus_sel, bus_we;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        hdr_rcvd, filt_match, wkup_sent, eng_idle;
    logic        xfer_done, xfer_abort, xfer_err, hdr_tx_done, dir_tx;
    logic        bit_err, par_err;
    logic        pol_bit_idle_o, pol_par_idle_o, req_wkup_o, req_discard_o, req_tx_o;
    logic        bit_chk_en_o, goto_idle_o;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    logic [4:0] m;  // model {tx, disc, wkup, par, bit}

    always #10 clk = ~clk;

    lin_req_ctl_reg dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_slave(cfg_slave), .mode_init(mode_init),
        .mode_sleep(mode_sleep), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .hdr_rcvd(hdr_rcvd), .filt_match(filt_match), .wkup_sent(wkup_sent),
        .eng_idle(eng_idle), .xfer_done(xfer_done), .xfer_abort(xfer_abort),
        .xfer_err(xfer_err), .hdr_tx_done(hdr_tx_done), .dir_tx(dir_tx),
        .bit_err(bit_err), .par_err(par_err),
        .pol_bit_idle_o(pol_bit_idle_o), .pol_par_idle_o(pol_par_idle_o),
        .req_wkup_o(req_wkup_o), .req_discard_o(req_discard_o), .req_tx_o(req_tx_o),
        .bit_chk_en_o(bit_chk_en_o), .goto_idle_o(goto_idle_o)
    );

    function automatic logic [4:0] model_next(input logic [4:0] s);
        logic [4:0] n = s;
        logic wr = bus_sel && bus_we && (bus_addr == 8'h30);
        if (wr && mode_init) n[1:0] = bus_wdata[17:16];
        if (wkup_sent) n[2] = 1'b0;
        else if (wr && bus_wdata[18] && !mode_sleep) n[2] = 1'b1;
        if (eng_idle) n[3] = 1'b0;
        else if (wr && bus_wdata[19] && (!cfg_slave || (hdr_rcvd && !filt_match))) n[3] = 1'b1;
        if (xfer_done || xfer_abort || xfer_err) n[4] = 1'b0;
        else if ((cfg_slave && wr && bus_wdata[20] && hdr_rcvd) ||
                 (!cfg_slave && hdr_tx_done && dir_tx)) n[4] = 1'b1;
        return n;
    endfunction

    function automatic logic [31:0] exp_rdata(input logic [4:0] s);
        if (bus_sel && !bus_we && bus_addr == 8'h30) return {11'b0, s, 16'b0};
        return 32'b0;
    endfunction

    function automatic logic exp_idle(input logic [4:0] s);
        return (bit_err && !s[2] && s[0]) || (par_err && s[1]);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic quiet();
        mode_init = 0; mode_sleep = 0; bus_sel = 0; bus_we = 0; bus_addr = 8'h30;
        bus_wdata = 0; hdr_rcvd = 0; filt_match = 0; wkup_sent = 0; eng_idle = 0;
        xfer_done = 0; xfer_abort = 0; xfer_err = 0; hdr_tx_done = 0; dir_tx = 0;
        bit_err = 0; par_err = 0;
    endtask

    task automatic wr(input logic [31:0] d);
        bus_sel = 1; bus_we = 1; bus_addr = 8'h30; bus_wdata = d;
    endtask

    // inputs already driven after a negedge: check combinational, clock, check state
    task automatic step(input string tag);
        #1;
        chk({tag, " R1 rdata"}, bus_rdata, exp_rdata(m));
        chk({tag, " R4 goto_idle"}, {31'b0, goto_idle_o}, {31'b0, exp_idle(m)});
        chk({tag, " R6 bit_chk_en"}, {31'b0, bit_chk_en_o}, {31'b0, !m[2]});
        m = model_next(m);
        @(negedge clk);
        chk({tag, " R3 policy"}, {30'b0, pol_par_idle_o, pol_bit_idle_o}, {30'b0, m[1:0]});
        chk({tag, " R5 wkup"}, {31'b0, req_wkup_o}, {31'b0, m[2]});
        chk({tag, " R7 discard"}, {31'b0, req_discard_o}, {31'b0, m[3]});
        chk({tag, " R9 tx"}, {31'b0, req_tx_o}, {31'b0, m[4]});
    endtask

    task automatic do_reset(input logic slave);
        quiet();
        cfg_slave = slave;
        rst_n = 0;
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        m = {4'b0, slave};
        chk("R2 reset word", {27'b0, req_tx_o, req_discard_o, req_wkup_o,
                              pol_par_idle_o, pol_bit_idle_o}, {27'b0, m});
        bus_sel = 1; bus_we = 0; #1;
        chk("R2 reset readback", bus_rdata, {11'b0, m, 16'b0});
        quiet();
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 0;
        quiet();
        cfg_slave = 1;
        @(negedge clk);

        // ---------- slave mode directed ----------
        do_reset(1'b1);
        quiet(); wr(32'h0003_0000); step("R3 policy write outside init");
        quiet(); mode_init = 1; wr(32'h0002_0000); step("R3 policy write in init");
        quiet(); bit_err = 1; par_err = 1; step("R4 parity idle");
        quiet(); mode_sleep = 1; wr(32'h0004_0000); step("R5 wkup in sleep");
        quiet(); wr(32'h0000_0000); step("R5 write zero");
        quiet(); wr(32'h0004_0000); step("R5 wkup set");
        quiet(); bit_err = 1; step("R6 bit check off during wkup");
        quiet(); wkup_sent = 1; wr(32'h0004_0000); step("R12 wkup clear vs set");
        quiet(); hdr_rcvd = 1; filt_match = 1; wr(32'h0008_0000); step("R7 discard with match");
        quiet(); wr(32'h0008_0000); step("R7 discard without header");
        quiet(); hdr_rcvd = 1; wr(32'h0018_0000); step("R7 R9 discard and tx set");
        quiet(); eng_idle = 1; step("R8 discard cleared on idle");
        quiet(); xfer_abort = 1; step("R10 tx cleared on abort");
        quiet(); hdr_rcvd = 1; xfer_err = 1; wr(32'h0010_0000); step("R12 tx clear vs set");
        quiet(); hdr_rcvd = 1; eng_idle = 1; wr(32'h0008_0000); step("R12 discard clear vs set");
        quiet(); bus_addr = 8'h34; wr(32'h001F_0000); bus_addr = 8'h34; step("R1 other address");
        quiet(); bus_sel = 1; bus_addr = 8'h2C; step("R1 read other address");

        // ---------- master mode directed ----------
        do_reset(1'b0);
        quiet(); hdr_rcvd = 1; wr(32'h0010_0000); step("R9 master sw tx ignored");
        quiet(); hdr_tx_done = 1; dir_tx = 0; step("R11 receive direction");
        quiet(); hdr_tx_done = 1; dir_tx = 1; step("R11 master hw set");
        quiet(); xfer_done = 1; step("R10 tx cleared on done");
        quiet(); hdr_tx_done = 1; dir_tx = 1; xfer_err = 1; step("R12 hw set vs clear");
        quiet(); filt_match = 1; wr(32'h0008_0000); step("R7 master discard ungated");

        // ---------- constrained random, both roles ----------
        for (int r = 0; r < 2; r++) begin
            do_reset(r[0]);
            for (int i = 0; i < 3000; i++) begin
                quiet();
                mode_init   = ($urandom % 4) == 0;
                mode_sleep  = ($urandom % 5) == 0;
                bus_sel     = ($urandom % 3) != 0;
                bus_we      = $urandom % 2;
                bus_addr    = (($urandom % 6) == 0) ? 8'($urandom) : 8'h30;
                bus_wdata   = $urandom;
                hdr_rcvd    = $urandom % 2;
                filt_match  = $urandom % 2;
                wkup_sent   = ($urandom % 6) == 0;
                eng_idle    = ($urandom % 6) == 0;
                xfer_done   = ($urandom % 10) == 0;
                xfer_abort  = ($urandom % 12) == 0;
                xfer_err    = ($urandom % 12) == 0;
                hdr_tx_done = ($urandom % 4) == 0;
                dir_tx      = $urandom % 2;
                bit_err     = ($urandom % 3) == 0;
                par_err     = ($urandom % 3) == 0;
                step("random");
            end
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule